// File: doc/BRIEF.md
# Chip Reset Controller

This block collects every reset request in a small chip and turns them into reset outputs of three reaches. The system reset covers everything. The CPU reset covers only the processor. Each peripheral module also has its own reset. Requests come from four places:

- an active-low external reset pin;
- a chip-enable pin and a power-good indication, which together form the power reset;
- a watchdog request, which is acted on only after a fixed preparation delay;
- a control register written by software.

The control register holds one-shot bits for a system reset, a CPU reset and one reset per module.

Every output is asserted at once, either asynchronously or on the sampling edge. Every output is held for a minimum number of cycles after its request goes away. Every output is released through a two-stage synchronizer. A sticky cause register records which sources have fired since the last power reset. Software clears its bits by writing ones to them. System and CPU resets leave the cause register untouched.

Top module: `rstmgr_top`

## Requirements
- R1: While `pinRstN` is low, all reset outputs are low with no clock needed. After the pin returns high, the outputs stay low for exactly MIN_CYC+2 further samples. Cause bit 0 (pin) is then set.
- R2: While `chipEn` or `pwrGood` is low, all reset outputs are low. The cause register is forced to 5'b00010, so that only bit 1 (power) is set.
- R3: A rising edge of `wdtReq` starts a PREP_CYC-cycle preparation. At its end `prepDone` pulses high for exactly one cycle, and cause bit 2 (watchdog) is set. The system reset is asserted on the next clock edge. A rising edge that arrives during the preparation is ignored.
- R4: A write with `ctlWrData` bit 0 set asserts the system, CPU and all module resets, and sets cause bit 3 (software system).
- R5: A write with `ctlWrData` bit 1 set asserts only the CPU reset, and sets cause bit 4 (software CPU).
- R6: A write with `ctlWrData` bit 2+i set asserts only module reset i. It sets no cause bit, so any pattern of modules can be reset together.
- R7: A request lasting one cycle holds the affected output low for exactly MIN_CYC+2 clock cycles. The output is released synchronously.
- R8: Cause bits are sticky and survive system and CPU resets. Writing a one to a bit in `causeClrMask` while `causeClrEn` is high clears that bit. A new event in the same cycle wins over the clear.
- R9: Control bits clear themselves after one cycle. Only a 0-to-1 change is acted on, so holding a write for several cycles gives a single reset.
- R10: Whenever the system reset is asserted, the CPU reset and every module reset are asserted as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pinRstN | input | 1 | External reset pin, active low |
| chipEn | input | 1 | Chip enable; low holds the power reset |
| pwrGood | input | 1 | Supply good; low holds the power reset |
| wdtReq | input | 1 | Watchdog reset request; its rising edge counts |
| ctlWrEn | input | 1 | Write strobe for the software reset control bits |
| ctlWrData | input | NUM_MOD+2 | Bit 0 system, bit 1 CPU, bit 2+i module i |
| causeClrEn | input | 1 | Write strobe for clearing cause bits |
| causeClrMask | input | 5 | Ones select the cause bits to clear |
| sysRstN | output | 1 | System reset, active low |
| cpuRstN | output | 1 | CPU reset, active low |
| modRstN | output | NUM_MOD | Per-module resets, active low |
| prepDone | output | 1 | One-cycle pulse at the end of the watchdog preparation |
| cause | output | 5 | Sticky causes: 0 pin, 1 power, 2 watchdog, 3 sw system, 4 sw CPU |

## Verification
The bench builds the block with NUM_MOD=3 and MIN_CYC=4, and keeps the default PREP_CYC of 8. With only three modules, every combination of the CPU bit and the module bits (16 patterns) can be driven. For each pattern the bench checks how long each output stays low against MIN_CYC+2 or zero. The short hold window keeps the pin, power, watchdog and held-write cases brief enough to count exactly. The bench also follows the cause register through a full sequence of set and clear operations.

// File: rtl/rstmgr_pkg.sv
package rstmgr_pkg;
  localparam int CAUSE_W = 5;

  typedef enum int {
    CZ_PIN   = 0,
    CZ_PWR   = 1,
    CZ_WDT   = 2,
    CZ_SWSYS = 3,
    CZ_SWCPU = 4
  } causeIdx_e;

  localparam logic [CAUSE_W-1:0] CAUSE_PWR_INIT = 5'b00010;

  typedef struct packed {
    logic sysReq;
    logic cpuReq;
    logic wdtDone;
  } rstStrobe_t;
endpackage

// File: rtl/rstmgr_ctrl.sv
module rstmgr_ctrl
  import rstmgr_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int PREP_CYC = 8,
  localparam int CTL_W   = NUM_MOD + 2,
  localparam int PC_W    = (PREP_CYC > 1) ? $clog2(PREP_CYC) : 1
) (
  input  logic               clk,
  input  logic               hardRstN,
  input  logic               pwrRstN,
  input  logic               pinRstN,
  input  logic               wdtReq,
  input  logic               ctlWrEn,
  input  logic [CTL_W-1:0]   ctlWrData,
  input  logic               causeClrEn,
  input  logic [CAUSE_W-1:0] causeClrMask,
  output rstStrobe_t         strobe,
  output logic [NUM_MOD-1:0] modReq,
  output logic [CAUSE_W-1:0] cause
);
  logic [CTL_W-1:0]   ctlQ, ctlPrev, ctlEdge;
  logic               wdtPrev, busy, done;
  logic [PC_W-1:0]    pc;
  logic               pinS1, pinS2;
  logic [CAUSE_W-1:0] setVec, clrVec;

  // software bits self-clear; prepare counter for watchdog
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      ctlQ    <= '0;
      ctlPrev <= '0;
      wdtPrev <= 1'b0;
      busy    <= 1'b0;
      pc      <= '0;
      done    <= 1'b0;
    end else begin
      ctlQ    <= ctlWrEn ? ctlWrData : '0;
      ctlPrev <= ctlQ;
      wdtPrev <= wdtReq;
      done    <= 1'b0;
      if (busy) begin
        if (pc == PC_W'(PREP_CYC - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
      end else if (wdtReq && !wdtPrev) begin
        busy <= 1'b1;
        pc   <= '0;
      end
    end
  end

  assign ctlEdge = ctlQ & ~ctlPrev;

  // pin level seen in the power-only domain so the cause survives pin reset
  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) begin
      pinS1 <= 1'b1;
      pinS2 <= 1'b1;
    end else begin
      pinS1 <= pinRstN;
      pinS2 <= pinS1;
    end
  end

  always_comb begin
    setVec           = '0;
    setVec[CZ_PIN]   = ~pinS2;
    setVec[CZ_WDT]   = done;
    setVec[CZ_SWSYS] = ctlEdge[0];
    setVec[CZ_SWCPU] = ctlEdge[1];
    clrVec           = causeClrEn ? causeClrMask : '0;
  end

  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) cause <= CAUSE_PWR_INIT;
    else          cause <= (cause & ~clrVec) | setVec;
  end

  assign strobe.sysReq  = done | ctlEdge[0];
  assign strobe.cpuReq  = ctlEdge[1];
  assign strobe.wdtDone = done;
  assign modReq         = ctlEdge[CTL_W-1:2];
endmodule

// File: rtl/rstmgr_dom.sv
module rstmgr_dom #(
  parameter int MIN_CYC = 16,
  localparam int CNT_W  = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic hardRstN,
  input  logic req,
  output logic rstN
);
  logic [CNT_W-1:0] cnt;
  logic             s1, s2;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      cnt <= '0;
      s1  <= 1'b0;
      s2  <= 1'b0;
    end else if (req) begin
      cnt <= '0;
      s1  <= 1'b0;
      s2  <= 1'b0;
    end else begin
      if (cnt != CNT_W'(MIN_CYC)) cnt <= cnt + 1'b1;
      s1 <= (cnt == CNT_W'(MIN_CYC));
      s2 <= s1;
    end
  end

  assign rstN = s2;
endmodule

// File: rtl/rstmgr_dp.sv
module rstmgr_dp
  import rstmgr_pkg::*;
#(
  parameter int NUM_MOD = 4,
  parameter int MIN_CYC = 16
) (
  input  logic               clk,
  input  logic               hardRstN,
  input  rstStrobe_t         strobe,
  input  logic [NUM_MOD-1:0] modReq,
  output logic               sysRstN,
  output logic               cpuRstN,
  output logic [NUM_MOD-1:0] modRstN
);
  rstmgr_dom #(.MIN_CYC(MIN_CYC)) u_sys (
    .clk(clk), .hardRstN(hardRstN), .req(strobe.sysReq), .rstN(sysRstN));

  rstmgr_dom #(.MIN_CYC(MIN_CYC)) u_cpu (
    .clk(clk), .hardRstN(hardRstN), .req(strobe.sysReq | strobe.cpuReq),
    .rstN(cpuRstN));

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    rstmgr_dom #(.MIN_CYC(MIN_CYC)) u_mod (
      .clk(clk), .hardRstN(hardRstN), .req(strobe.sysReq | modReq[i]),
      .rstN(modRstN[i]));
  end
endmodule

// File: rtl/rstmgr_top.sv
module rstmgr_top
  import rstmgr_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int MIN_CYC  = 16,
  parameter int PREP_CYC = 8
) (
  input  logic               clk,
  input  logic               pinRstN,
  input  logic               chipEn,
  input  logic               pwrGood,
  input  logic               wdtReq,
  input  logic               ctlWrEn,
  input  logic [NUM_MOD+1:0] ctlWrData,
  input  logic               causeClrEn,
  input  logic [4:0]         causeClrMask,
  output logic               sysRstN,
  output logic               cpuRstN,
  output logic [NUM_MOD-1:0] modRstN,
  output logic               prepDone,
  output logic [4:0]         cause
);
  logic               pwrRstN, hardRstN;
  rstStrobe_t         strobe;
  logic [NUM_MOD-1:0] modReq;

  assign pwrRstN  = chipEn & pwrGood;
  assign hardRstN = pwrRstN & pinRstN;

  rstmgr_ctrl #(.NUM_MOD(NUM_MOD), .PREP_CYC(PREP_CYC)) u_ctrl (
    .clk(clk), .hardRstN(hardRstN), .pwrRstN(pwrRstN), .pinRstN(pinRstN),
    .wdtReq(wdtReq), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .causeClrEn(causeClrEn), .causeClrMask(causeClrMask),
    .strobe(strobe), .modReq(modReq), .cause(cause));

  rstmgr_dp #(.NUM_MOD(NUM_MOD), .MIN_CYC(MIN_CYC)) u_dp (
    .clk(clk), .hardRstN(hardRstN), .strobe(strobe), .modReq(modReq),
    .sysRstN(sysRstN), .cpuRstN(cpuRstN), .modRstN(modRstN));

  assign prepDone = strobe.wdtDone;
endmodule

// File: rtl/rstmgr_chk.sv
module rstmgr_chk #(
  parameter int NUM_MOD = 4
) (
  input logic               clk,
  input logic               pinRstN,
  input logic               chipEn,
  input logic               pwrGood,
  input logic               causeClrEn,
  input logic               prepDone,
  input logic               sysRstN,
  input logic               cpuRstN,
  input logic [NUM_MOD-1:0] modRstN,
  input logic [4:0]         cause
);
  logic allOk, pwrOk;
  assign pwrOk = chipEn & pwrGood;
  assign allOk = pwrOk & pinRstN;

  AST_SCOPE_NEST: assert property (@(posedge clk) disable iff (!allOk)
    !sysRstN |-> (!cpuRstN && modRstN == '0)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!allOk)
    prepDone |=> !prepDone); // R3

  AST_DONE_THEN_SYS: assert property (@(posedge clk) disable iff (!allOk)
    prepDone |=> !sysRstN); // R3

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!allOk)
    $fell(sysRstN) |=> !sysRstN); // R7

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!pwrOk)
    !causeClrEn |=> ((cause & $past(cause)) == $past(cause))); // R8
endmodule

bind rstmgr_top rstmgr_chk #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk(clk), .pinRstN(pinRstN), .chipEn(chipEn), .pwrGood(pwrGood),
  .causeClrEn(causeClrEn), .prepDone(prepDone), .sysRstN(sysRstN),
  .cpuRstN(cpuRstN), .modRstN(modRstN), .cause(cause));

// File: tb/rstmgr_top_tb.sv
`timescale 1ns/1ps
module rstmgr_top_tb;
  localparam int NM   = 3;
  localparam int MINC = 4;
  localparam int PREP = 8;
  localparam int HOLD = MINC + 2;

  logic clk = 1'b0;
  logic pinRstN = 1'b1, chipEn = 1'b0, pwrGood = 1'b1, wdtReq = 1'b0;
  logic ctlWrEn = 1'b0, causeClrEn = 1'b0;
  logic [NM+1:0] ctlWrData = '0;
  logic [4:0] causeClrMask = '0;
  logic sysRstN, cpuRstN, prepDone;
  logic [NM-1:0] modRstN;
  logic [4:0] cause;

  int total = 0, bad = 0;
  int lowSys = 0, lowCpu = 0, doneCnt = 0;
  int lowMod [NM];
  int bSys, bCpu, bDone;
  int bMod [NM];
  bit finished = 0;

  always #2 clk = ~clk;

  rstmgr_top #(.NUM_MOD(NM), .MIN_CYC(MINC), .PREP_CYC(PREP)) u_dut (
    .clk(clk), .pinRstN(pinRstN), .chipEn(chipEn), .pwrGood(pwrGood),
    .wdtReq(wdtReq), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .causeClrEn(causeClrEn), .causeClrMask(causeClrMask),
    .sysRstN(sysRstN), .cpuRstN(cpuRstN), .modRstN(modRstN),
    .prepDone(prepDone), .cause(cause));

  initial for (int i = 0; i < NM; i++) lowMod[i] = 0;

  always @(negedge clk) begin
    #1;
    if (!sysRstN) lowSys++;
    if (!cpuRstN) lowCpu++;
    if (prepDone) doneCnt++;
    for (int i = 0; i < NM; i++) if (!modRstN[i]) lowMod[i]++;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    bSys = lowSys; bCpu = lowCpu; bDone = doneCnt;
    for (int i = 0; i < NM; i++) bMod[i] = lowMod[i];
  endtask

  task automatic checkLows(string req, int eSys, int eCpu, int eMod [NM]);
    check({req, " sys"}, lowSys - bSys, eSys);
    check({req, " cpu"}, lowCpu - bCpu, eCpu);
    for (int i = 0; i < NM; i++) check({req, " mod"}, lowMod[i] - bMod[i], eMod[i]);
  endtask

  task automatic swWrite(logic [NM+1:0] d, int cyc);
    @(negedge clk);
    snap();
    ctlWrEn = 1'b1; ctlWrData = d;
    repeat (cyc) @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0;
    repeat (20) @(negedge clk);
    #2;
  endtask

  task automatic clearCause(logic [4:0] m);
    @(negedge clk);
    causeClrEn = 1'b1; causeClrMask = m;
    @(negedge clk);
    causeClrEn = 1'b0; causeClrMask = '0;
    @(negedge clk);
    #2;
  endtask

  initial begin
    int eM [NM];
    int doneAt, sysAt;
    // reset state: power held off
    repeat (3) @(negedge clk);
    #2;
    check("R2 reset sys", int'(sysRstN), 0);
    check("R2 reset cpu", int'(cpuRstN), 0);
    check("R2 reset mod", int'(modRstN), 0);
    check("R2 reset cause", int'(cause), 2);
    @(negedge clk);
    snap();
    chipEn = 1'b1;
    repeat (20) @(negedge clk);
    #2;
    for (int i = 0; i < NM; i++) eM[i] = HOLD;
    checkLows("R7 power release", HOLD, HOLD, eM);

    // R1: pin reset held 5 cycles
    @(negedge clk);
    snap();
    pinRstN = 1'b0;
    #1;
    check("R1 async sys", int'(sysRstN), 0);
    check("R1 async mod", int'(modRstN), 0);
    repeat (5) @(negedge clk);
    pinRstN = 1'b1;
    repeat (20) @(negedge clk);
    #2;
    for (int i = 0; i < NM; i++) eM[i] = 5 + HOLD;
    checkLows("R1 pin", 5 + HOLD, 5 + HOLD, eM);
    check("R1 cause", int'(cause), 5'b00011);
    clearCause(5'b00001);
    check("R8 w1c pin", int'(cause), 5'b00010);

    // R3: watchdog
    @(negedge clk);
    snap();
    wdtReq = 1'b1;
    doneAt = 0; sysAt = 0;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      #1;
      if (j == 3) wdtReq = 1'b0;
      if (j == 4) wdtReq = 1'b1; // second rise during preparation: ignored
      if (prepDone && doneAt == 0) doneAt = j;
      if (!sysRstN && sysAt == 0) sysAt = j;
    end
    wdtReq = 1'b0;
    #1;
    check("R3 done time", doneAt, PREP + 1);
    check("R3 sys time", sysAt, PREP + 2);
    check("R3 done count", doneCnt - bDone, 1);
    for (int i = 0; i < NM; i++) eM[i] = HOLD;
    checkLows("R3 wdt", HOLD, HOLD, eM);
    check("R3 cause", int'(cause), 5'b00110);

    // R4/R10: software system reset
    swWrite(5'b00001, 1);
    for (int i = 0; i < NM; i++) eM[i] = HOLD;
    checkLows("R4 R10 swsys", HOLD, HOLD, eM);
    check("R4 R8 cause", int'(cause), 5'b01110);

    // R5: software CPU reset
    swWrite(5'b00010, 1);
    for (int i = 0; i < NM; i++) eM[i] = 0;
    checkLows("R5 swcpu", 0, HOLD, eM);
    check("R5 cause", int'(cause), 5'b11110);
    clearCause(5'b11111);
    check("R8 clear all", int'(cause), 0);

    // R6/R7: sweep every cpu/module combination
    for (int v = 0; v < (1 << (NM + 1)); v++) begin
      swWrite({v[NM:0], 1'b0}, 1);
      for (int i = 0; i < NM; i++) eM[i] = v[i + 1] ? HOLD : 0;
      checkLows("R6 R7 sweep", 0, v[0] ? HOLD : 0, eM);
    end
    check("R6 no module cause", int'(cause[3:0]), 0);

    // R9: held write acts once
    swWrite(5'b00010, 3);
    for (int i = 0; i < NM; i++) eM[i] = 0;
    checkLows("R9 held", 0, HOLD, eM);

    // R2: power loss restores cause
    @(negedge clk);
    pwrGood = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check("R2 pwr sys", int'(sysRstN), 0);
    check("R2 pwr cpu", int'(cpuRstN), 0);
    @(negedge clk);
    pwrGood = 1'b1;
    repeat (20) @(negedge clk);
    #2;
    check("R2 pwr cause", int'(cause), 2);
    check("R2 pwr released", int'(sysRstN), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule